// File: doc/BRIEF.md
# Packed Lane Add, Logic and Compare Unit

This block is a 64-bit packed integer datapath stage. One cycle takes two 64-bit operands, a destination operand and a source operand, together with an operation code and a lane-size code. The word is treated as eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes, and each lane is computed separately. The operations are wrapping add and subtract, signed and unsigned saturating add and subtract, equality and signed greater-than compares that produce lane masks, and four bitwise operations that ignore lanes.

The result is captured in an output register on the clock edge that samples the input strobe. The output strobe is raised for exactly that one following cycle. Between strobes the result register holds its last value. Operations that have no meaning, such as saturation on 32-bit lanes, an unused lane-size code or an unused operation code, produce an all-zero result. This keeps the output deterministic for a decoder that sends them.

Top module: `simd_alu`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid` and `result` are cleared to zero at that edge.
- R2: `out_valid` is high in the cycle after `in_valid` was sampled high and low otherwise. `result` loads only on a sampled `in_valid` and otherwise keeps its value.
- R3: Code 0 (wrapping add) adds each lane of `dst` and `src` modulo 2^W. `lsize` 0, 1 and 2 select W = 8, 16 and 32. No carry crosses a lane boundary.
- R4: Code 1 (wrapping subtract) computes `dst - src` per lane modulo 2^W. No borrow crosses a lane boundary.
- R5: Codes 2 (signed saturating add) and 3 (signed saturating subtract) on 8- or 16-bit lanes clamp each lane to 2^(W-1)-1 on positive overflow and to -2^(W-1) on negative overflow.
- R6: Codes 4 (unsigned saturating add) and 5 (unsigned saturating subtract) on 8- or 16-bit lanes clamp each lane to all ones when an add overflows and to zero when a subtract underflows.
- R7: Codes 6 (AND), 8 (OR) and 9 (XOR) act bitwise on the full 64-bit word for every `lsize` value, including 3.
- R8: Code 7 (AND-NOT) yields `~dst & src` on the full word for every `lsize` value.
- R9: Code 10 (equality compare) sets a lane to all ones when the `dst` and `src` lanes are equal and to all zeros otherwise.
- R10: Code 11 (greater-than compare) sets a lane to all ones when the `dst` lane, read as a two's-complement value, is greater than the `src` lane, and to zeros otherwise.
- R11: A zero result is produced for any of these inputs: codes 12 to 15; `lsize` 3 with any non-bitwise code; codes 2 to 5 with `lsize` 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and codes are valid this cycle |
| op | input | 4 | Operation code |
| lsize | input | 2 | Lane size code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| dst | input | 64 | Destination operand (minuend, left side of compares) |
| src | input | 64 | Source operand |
| out_valid | output | 1 | Result register was loaded on the last edge |
| result | output | 64 | Registered result |

## Verification
Saturation and lane isolation can meet in one word. A lane that clamps can sit directly beside a lane that wraps or stays in range, so a clamp that leaks into its neighbour, or a carry that leaks out of a clamped lane, would corrupt the other lane. The bench provokes this by building operands byte by byte from 00, 7F, 80, FF and random values, so lanes at the signed and unsigned limits mix inside one word at every lane size. Each lane of the result is then compared with a bench model that computes every lane with integer arithmetic. Random gaps in `in_valid` also test the hold behaviour of the result register between strobes.

// File: rtl/simd_pkg.sv
// Package: shared widths and codes for the packed lane datapath.
// Assumes the data word is a multiple of the widest lane (32 bits).
package simd_pkg;

    localparam int DATA_W    = 64;
    localparam int NUM_SIZES = 3;   // 8, 16 and 32-bit lanes

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_SUB    = 4'd1,
        OP_ADDSS  = 4'd2,
        OP_SUBSS  = 4'd3,
        OP_ADDUS  = 4'd4,
        OP_SUBUS  = 4'd5,
        OP_AND    = 4'd6,
        OP_ANDN   = 4'd7,
        OP_OR     = 4'd8,
        OP_XOR    = 4'd9,
        OP_CMPEQ  = 4'd10,
        OP_CMPGT  = 4'd11
    } simd_op_e;

    typedef enum logic [1:0] {
        SAT_NONE     = 2'd0,
        SAT_SIGNED   = 2'd1,
        SAT_UNSIGNED = 2'd2
    } sat_e;

    localparam logic [1:0] LS_WIDEST_SAT = 2'd1;  // largest code allowed with saturation
    localparam logic [1:0] LS_RESERVED   = 2'd3;

endpackage

// File: rtl/simd_lane_slice.sv
// Module: one lane of width W. Adds or subtracts with optional signed or
// unsigned clamping, and reports equality and signed greater-than.
// Assumes W >= 2. Subtraction is a - b computed as a + ~b + 1.
module simd_lane_slice
    import simd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub_en,
    input  sat_e         sat_mode,
    output logic [W-1:0] arith,
    output logic         eq,
    output logic         gt
);

    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] b_eff;
    logic [W:0]   sum;
    logic         ovf_signed;
    logic         ovf_unsigned;

    // Lane-local adder: the carry chain stops at bit W.
    always_comb begin
        b_eff        = b ^ {W{sub_en}};
        sum          = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub_en};
        ovf_signed   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
        ovf_unsigned = sub_en ? ~sum[W] : sum[W];
    end

    // Clamp selection by saturation mode.
    always_comb begin
        unique case (sat_mode)
            SAT_SIGNED:   arith = ovf_signed ? (a[W-1] ? SMIN : SMAX) : sum[W-1:0];
            SAT_UNSIGNED: arith = ovf_unsigned ? (sub_en ? '0 : '1) : sum[W-1:0];
            default:      arith = sum[W-1:0];
        endcase
    end

    // Lane compares, destination on the left.
    always_comb begin
        eq = (a == b);
        gt = ($signed(a) > $signed(b));
    end

endmodule

// File: rtl/simd_lane_bank.sv
// Module: splits the data word into lanes of width LW and runs one slice
// per lane. Compare flags are widened to full-lane masks.
// Assumes DW is a multiple of LW.
module simd_lane_bank
    import simd_pkg::*;
#(
    parameter int DW = 64,
    parameter int LW = 8
) (
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] src,
    input  logic          sub_en,
    input  sat_e          sat_mode,
    output logic [DW-1:0] arith,
    output logic [DW-1:0] eq_mask,
    output logic [DW-1:0] gt_mask
);

    localparam int LANES = DW / LW;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic eq_l;
        logic gt_l;

        simd_lane_slice #(.W(LW)) u_slice (
            .a        (dst[i*LW +: LW]),
            .b        (src[i*LW +: LW]),
            .sub_en   (sub_en),
            .sat_mode (sat_mode),
            .arith    (arith[i*LW +: LW]),
            .eq       (eq_l),
            .gt       (gt_l)
        );

        // Spread the lane flags over the lane.
        assign eq_mask[i*LW +: LW] = {LW{eq_l}};
        assign gt_mask[i*LW +: LW] = {LW{gt_l}};
    end

endmodule

// File: rtl/simd_logic_unit.sv
// Module: full-width bitwise operations, with no lane structure.
// Assumes the caller keeps only the output for a bitwise code.
module simd_logic_unit
    import simd_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] src,
    input  simd_op_e      op,
    output logic [DW-1:0] res
);

    // Pick the bitwise function; ANDN inverts the destination.
    always_comb begin
        unique case (op)
            OP_AND:  res = dst & src;
            OP_ANDN: res = ~dst & src;
            OP_OR:   res = dst | src;
            OP_XOR:  res = dst ^ src;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/simd_alu.sv
// Module: top of the packed lane datapath. Decodes the operation, runs one
// lane bank per lane size, selects a result and registers it with a strobe.
// Assumes a synchronous active-low reset and DW a multiple of 32.
module simd_alu
    import simd_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    op,
    input  logic [1:0]    lsize,
    input  logic [DW-1:0] dst,
    input  logic [DW-1:0] src,
    output logic          out_valid,
    output logic [DW-1:0] result
);

    simd_op_e      op_e;
    logic          sub_en;
    sat_e          sat_mode;
    logic [DW-1:0] bank_arith [NUM_SIZES];
    logic [DW-1:0] bank_eq    [NUM_SIZES];
    logic [DW-1:0] bank_gt    [NUM_SIZES];
    logic [DW-1:0] logic_res;
    logic [DW-1:0] sel_arith;
    logic [DW-1:0] sel_eq;
    logic [DW-1:0] sel_gt;
    logic [DW-1:0] next_res;

    // Decode the adder control shared by every lane bank.
    always_comb begin
        op_e     = simd_op_e'(op);
        sub_en   = (op_e == OP_SUB) || (op_e == OP_SUBSS) || (op_e == OP_SUBUS);
        sat_mode = SAT_NONE;
        if (op_e == OP_ADDSS || op_e == OP_SUBSS) sat_mode = SAT_SIGNED;
        if (op_e == OP_ADDUS || op_e == OP_SUBUS) sat_mode = SAT_UNSIGNED;
    end

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_bank
        simd_lane_bank #(.DW(DW), .LW(8 << k)) u_bank (
            .dst      (dst),
            .src      (src),
            .sub_en   (sub_en),
            .sat_mode (sat_mode),
            .arith    (bank_arith[k]),
            .eq_mask  (bank_eq[k]),
            .gt_mask  (bank_gt[k])
        );
    end

    simd_logic_unit #(.DW(DW)) u_logic (
        .dst (dst),
        .src (src),
        .op  (op_e),
        .res (logic_res)
    );

    // Choose the bank matching the lane size; the reserved size gives zero.
    always_comb begin
        sel_arith = '0;
        sel_eq    = '0;
        sel_gt    = '0;
        if (lsize != LS_RESERVED) begin
            sel_arith = bank_arith[lsize];
            sel_eq    = bank_eq[lsize];
            sel_gt    = bank_gt[lsize];
        end
    end

    // Final result mux by operation class.
    always_comb begin
        next_res = '0;
        case (op_e)
            OP_ADD, OP_SUB:
                next_res = sel_arith;
            OP_ADDSS, OP_SUBSS, OP_ADDUS, OP_SUBUS:
                next_res = (lsize <= LS_WIDEST_SAT) ? sel_arith : '0;
            OP_AND, OP_ANDN, OP_OR, OP_XOR:
                next_res = logic_res;
            OP_CMPEQ:
                next_res = sel_eq;
            OP_CMPGT:
                next_res = sel_gt;
            default:
                next_res = '0;
        endcase
    end

    // Output register: loads on strobe, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_res;
        end
    end

endmodule

// File: rtl/simd_alu_chk.sv
// Module: property checker bound to the top. Watches ports only.
// Assumes the default 64-bit word.
module simd_alu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  op,
    input logic [1:0]  lsize,
    input logic [63:0] dst,
    input logic [63:0] src,
    input logic        out_valid,
    input logic [63:0] result
);

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && $past(rst_n)) |=> $stable(result)); // R2
    AST_SELF_SUB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd1 && dst == src) |=> (result == 64'd0)); // R4
    AST_USUB_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd5 && lsize < 2'd2 && src == 64'd0) |=> (result == $past(dst))); // R6
    AST_EQ_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd10 && lsize != 2'd3 && dst == src) |=> (result == '1)); // R9
    AST_GT_SELF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd11 && dst == src) |=> (result == 64'd0)); // R10
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op >= 4'd12) |=> (result == 64'd0)); // R11

endmodule

bind simd_alu simd_alu_chk u_chk (.*);

// File: tb/simd_alu_test.sv
module simd_alu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  lsize = '0;
    logic [63:0] dst = '0;
    logic [63:0] src = '0;
    logic        out_valid;
    logic [63:0] result;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    logic        exp_valid = 1'b0;
    logic [63:0] exp_res   = '0;
    string       exp_tag   = "R1";

    always #2 clk = ~clk;   // 250 MHz

    simd_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lsize(lsize),
        .dst(dst), .src(src), .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] ref_model(input logic [3:0] o, input logic [1:0] ls,
                                              input logic [63:0] d, input logic [63:0] s);
        logic [63:0] r = '0;
        int w;
        longint mask, a, b, sa, sb, v, hi, lo;
        case (o)
            4'd6: return d & s;
            4'd7: return ~d & s;
            4'd8: return d | s;
            4'd9: return d ^ s;
            default: ;
        endcase
        if (o > 4'd11 || ls == 2'd3) return '0;
        w = 8 << ls;
        if (o >= 4'd2 && o <= 4'd5 && w == 32) return '0;
        mask = (longint'(1) << w) - 1;
        hi = (longint'(1) << (w - 1)) - 1;
        lo = -(longint'(1) << (w - 1));
        for (int i = 0; i < 64 / w; i++) begin
            a  = longint'((d >> (i * w))) & mask;
            b  = longint'((s >> (i * w))) & mask;
            sa = (a > hi) ? a - (mask + 1) : a;
            sb = (b > hi) ? b - (mask + 1) : b;
            case (o)
                4'd0: v = a + b;
                4'd1: v = a - b;
                4'd2: begin v = sa + sb; v = (v > hi) ? hi : ((v < lo) ? lo : v); end
                4'd3: begin v = sa - sb; v = (v > hi) ? hi : ((v < lo) ? lo : v); end
                4'd4: begin v = a + b; if (v > mask) v = mask; end
                4'd5: v = (a < b) ? 0 : a - b;
                4'd10: v = (a == b) ? mask : 0;
                default: v = (sa > sb) ? mask : 0;
            endcase
            r = r | ((64'(v) & 64'(mask)) << (i * w));
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [3:0] o, input logic [1:0] ls);
        if (o > 4'd11) return "R11";
        if (o == 4'd6 || o == 4'd8 || o == 4'd9) return "R7";
        if (o == 4'd7) return "R8";
        if (ls == 2'd3) return "R11";
        if (o >= 4'd2 && o <= 4'd5 && ls == 2'd2) return "R11";
        case (o)
            4'd0: return "R3";
            4'd1: return "R4";
            4'd2, 4'd3: return "R5";
            4'd4, 4'd5: return "R6";
            4'd10: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [63:0] gen_word();
        logic [63:0] x;
        for (int i = 0; i < 8; i++) begin
            case ($urandom_range(0, 5))
                0: x[i*8 +: 8] = 8'h00;
                1: x[i*8 +: 8] = 8'h7F;
                2: x[i*8 +: 8] = 8'h80;
                3: x[i*8 +: 8] = 8'hFF;
                default: x[i*8 +: 8] = 8'($urandom);
            endcase
        end
        return x;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // At a falling edge: check what the last rising edge produced, then drive.
    task automatic step(input logic v, input logic [3:0] o, input logic [1:0] ls,
                        input logic [63:0] d, input logic [63:0] s);
        @(negedge clk);
        check("R2", {63'd0, out_valid}, {63'd0, exp_valid});
        check(exp_tag, result, exp_res);
        in_valid = v; op = o; lsize = ls; dst = d; src = s;
        exp_valid = v;
        if (v) begin
            exp_res = ref_model(o, ls, d, s);
            exp_tag = tag_of(o, ls);
        end else begin
            exp_tag = "R2";
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        in_valid = 1'b1; op = 4'd0; dst = '1; src = '1;
        repeat (3) @(negedge clk);
        check("R1", {63'd0, out_valid}, 64'd0);
        check("R1", result, 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        // Directed corners
        step(1, 4'd0, 2'd0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001); // R3 carry stops
        step(1, 4'd0, 2'd1, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001); // R3
        step(1, 4'd0, 2'd2, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001); // R3
        step(1, 4'd1, 2'd0, 64'h0100_0100_0100_0100, 64'h0001_0001_0001_0001); // R4 borrow stops
        step(1, 4'd2, 2'd0, 64'h7F80_7F80_0000_7F80, 64'h0180_0101_FFFF_7F80); // R5
        step(1, 4'd3, 2'd1, 64'h8000_7FFF_0001_8000, 64'h0001_FFFF_0002_7FFF); // R5
        step(1, 4'd4, 2'd0, 64'hFF01_FF01_80FE_0000, 64'h0101_FF00_8001_0000); // R6
        step(1, 4'd5, 2'd1, 64'h0000_FFFF_0001_8000, 64'h0001_FFFF_0002_7FFF); // R6
        step(1, 4'd7, 2'd3, 64'hF0F0_F0F0_0000_FFFF, 64'hFFFF_0000_FFFF_FFFF); // R8
        step(1, 4'd9, 2'd3, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_0000_FFFF_0000); // R7
        step(1, 4'd10, 2'd0, 64'h1122_3344_5566_7788, 64'h1122_0044_5566_0088); // R9
        step(1, 4'd11, 2'd0, 64'h807F_0001_FF00_7F80, 64'h7F80_0100_00FF_807F); // R10
        step(1, 4'd11, 2'd2, 64'h8000_0000_0000_0001, 64'h7FFF_FFFF_FFFF_FFFF); // R10
        step(1, 4'd2, 2'd2, 64'h7FFF_FFFF_7FFF_FFFF, 64'h1); // R11 no 32-bit saturation
        step(1, 4'd0, 2'd3, 64'h1, 64'h1); // R11 reserved size
        step(1, 4'd13, 2'd0, '1, '1); // R11 unused code
        step(0, 4'd0, 2'd0, 64'h5, 64'h5); // R2 hold
        step(0, 4'd1, 2'd1, 64'h9, 64'h2); // R2 hold
        // Random stream with gaps
        for (int n = 0; n < 4000; n++) begin
            step(($urandom_range(0, 3) != 0), 4'($urandom_range(0, 13)),
                 2'($urandom_range(0, 3)), gen_word(), gen_word());
        end
        step(0, 4'd0, 2'd0, '0, '0);
        @(negedge clk);
        check("R2", {63'd0, out_valid}, {63'd0, exp_valid});
        check(exp_tag, result, exp_res);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule